// File: doc/BRIEF.md
# Programmable 32-Source Interrupt Controller

This block gathers 32 interrupt sources and presents them to a processor as two request lines. Each source has its own 3-bit trigger code, built from one bit in each of three configuration words. The code selects whether the source is disabled, edge-sensitive (rising, falling or both) or level-sensitive (high or low). A per-source enable mask gates the source onto a request line. A per-source routing bit chooses which of the two lines it drives. A per-source wake bit lets a pending source raise a wake output even while it is masked.

Software controls every per-source bit word through a small register port. Each word has a read address, a set address and a clear address, and on the set and clear addresses only bits written as 1 take effect. Edge events are captured in separate rising and falling latch words and stay captured until software clears them. Each request line has a readable pending word. A per-source input-select bit picks either the external pin, which passes through a two-flop synchronizer, or the matching bit of a software-written test word. The test word lets firmware raise any source on its own.

Top module: `intc32`

## Requirements
- R1: After reset every configuration, mask, wake, route, input-select, test and latch word reads 0, and req0_o, req1_o and wake_o are low.
- R2: The address is split as wr_addr[4:2] = word (0 cfg0, 1 cfg1, 2 cfg2, 3 input-select, 4 route, 5 wake, 6 mask) and [1:0] = operation (0 read, 1 set, 2 clear). A set write ORs wr_data into the word, a clear write removes the bits that are 1 in wr_data, and bits written as 0 keep their value.
- R3: A source whose trigger code {cfg2,cfg1,cfg0} is 000 never becomes pending and never captures an edge.
- R4: In code 101 a source is pending while its selected input is 1, and in code 110 while it is 0. An external pin change shows up at the outputs two clock edges after it is applied.
- R5: Code 001 captures rising edges in the rising latch word (read 0x1C), code 010 captures falling edges in the falling latch word (read 0x1D), and code 011 captures both. An edge-mode source stays pending while its captured latch bit is set, after the input has returned.
- R6: Writing 1s to 0x1E clears those bits of the rising latch word and writing 1s to 0x1F clears those bits of the falling latch word. Other bits are untouched.
- R7: An enabled source with route bit 1 appears in pending word 0 (read 0x20) and drives req0_o. With route bit 0 it appears in pending word 1 (read 0x21) and drives req1_o. Each request is high exactly while its pending word is nonzero.
- R8: A source whose mask bit is 0 appears in neither pending word and drives neither request line.
- R9: wake_o is high while any source that has its wake bit set is active, whatever its mask bit.
- R10: With input-select bit 1 a source follows its external pin. With bit 0 it follows bit i of the test word (written at 0x23, read at 0x22), and its pin has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | External interrupt pins, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| req0_o | output | 1 | Request line 0, for high-priority sources |
| req1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wake indication |

## Verification
Level sources are driven high and low in both polarities, and the request is sampled one and two edges after the pin moves. This separates a correct synchronizer depth from a shorter or longer one. Three sources in rising, falling and both-edge modes are pulsed through a full high-low cycle, which shows whether each edge lands in the right latch word and whether pending persists once the pin returns. Partial clear writes then show that latches clear bit by bit. Mask, route, wake, disabled-code and test-word patterns each change one bit at a time, so each gate can be seen acting alone.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam logic [2:0] TRG_OFF  = 3'b000;
  localparam logic [2:0] TRG_RISE = 3'b001;
  localparam logic [2:0] TRG_FALL = 3'b010;
  localparam logic [2:0] TRG_BOTH = 3'b011;
  localparam logic [2:0] TRG_HIGH = 3'b101;
  localparam logic [2:0] TRG_LOW  = 3'b110;

  localparam int NUM_WORDS = 7;          // cfg0,cfg1,cfg2,isel,route,wake,mask
  localparam logic [1:0] OP_READ = 2'd0;
  localparam logic [1:0] OP_SET  = 2'd1;
  localparam logic [1:0] OP_CLR  = 2'd2;

  function automatic logic catches_rise(input logic [2:0] code);
    return (code == TRG_RISE) || (code == TRG_BOTH);
  endfunction

  function automatic logic catches_fall(input logic [2:0] code);
    return (code == TRG_FALL) || (code == TRG_BOTH);
  endfunction

  function automatic logic source_active(input logic [2:0] code, input logic lvl,
                                         input logic rq, input logic fq);
    case (code)
      TRG_RISE: return rq;
      TRG_FALL: return fq;
      TRG_BOTH: return rq | fq;
      TRG_HIGH: return lvl;
      TRG_LOW:  return ~lvl;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/intc_setclr.sv
module intc_setclr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] set_bits, clr_bits;
  assign set_bits = set_en ? wdata : '0;
  assign clr_bits = clr_en ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q | set_bits) & ~clr_bits;
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> ((q & $past(wdata)) == $past(wdata))); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((q & $past(wdata)) == '0)); // R2
  AST_ZERO_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en || clr_en) |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))); // R2
endmodule

// File: rtl/intc_detect.sv
module intc_detect
  import intc_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic [N-1:0] cfg0,
  input  logic [N-1:0] cfg1,
  input  logic [N-1:0] cfg2,
  input  logic [N-1:0] clr_rise,
  input  logic [N-1:0] clr_fall,
  output logic [N-1:0] rise_q,
  output logic [N-1:0] fall_q,
  output logic [N-1:0] active
);
  logic [N-1:0] prev;
  logic [N-1:0] rise_evt, fall_evt;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic [2:0] code;
    assign code        = {cfg2[i], cfg1[i], cfg0[i]};
    assign rise_evt[i] = src[i] & ~prev[i] & catches_rise(code);
    assign fall_evt[i] = ~src[i] & prev[i] & catches_fall(code);
    assign active[i]   = source_active(code, src[i], rise_q[i], fall_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev   <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      prev   <= src;
      // a new event wins over a clear in the same cycle
      rise_q <= (rise_q & ~clr_rise) | rise_evt;
      fall_q <= (fall_q & ~clr_fall) | fall_evt;
    end
  end

  AST_RISE_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt != '0) |=> ((rise_q & $past(rise_evt)) == $past(rise_evt))); // R5
  AST_FALL_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt != '0) |=> ((fall_q & $past(fall_evt)) == $past(fall_evt))); // R5
  AST_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_q & ~$past(rise_q) & ~$past(src & ~prev)) == '0)); // R5
  AST_OFF_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (((rise_q | fall_q) & ~$past(rise_q | fall_q) & ~$past(cfg0 | cfg1 | cfg2)) == '0)); // R3
endmodule

// File: rtl/intc32.sv
module intc32
  import intc_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NSRC-1:0]   wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NSRC-1:0]   rd_data,
  output logic              req0_o,
  output logic              req1_o,
  output logic              wake_o
);
  localparam int W_CFG0 = 0, W_CFG1 = 1, W_CFG2 = 2, W_ISEL = 3;
  localparam int W_ROUTE = 4, W_WAKE = 5, W_MASK = 6;

  logic [NSRC-1:0] words [NUM_WORDS];
  logic [2:0] wgrp, rgrp;
  logic [1:0] wop, rop;
  logic       whi, rhi;

  assign whi  = wr_addr[5];
  assign wgrp = wr_addr[4:2];
  assign wop  = wr_addr[1:0];
  assign rhi  = rd_addr[5];
  assign rgrp = rd_addr[4:2];
  assign rop  = rd_addr[1:0];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic hit;
    assign hit = wr_en && !whi && (wgrp == 3'(g));
    intc_setclr #(.W(NSRC)) u_word (
      .clk(clk), .rst_n(rst_n),
      .set_en(hit && wop == OP_SET),
      .clr_en(hit && wop == OP_CLR),
      .wdata(wr_data), .q(words[g]));
  end

  // test word: plain write at 0x23
  logic [NSRC-1:0] test_q;
  always_ff @(posedge clk) begin
    if (!rst_n) test_q <= '0;
    else if (wr_en && wr_addr == 6'h23) test_q <= wr_data;
  end

  logic [NSRC-1:0] pin_sync, src_sel;
  intc_sync #(.W(NSRC)) u_sync (.clk(clk), .rst_n(rst_n), .d(irq_in), .q(pin_sync));
  assign src_sel = (pin_sync & words[W_ISEL]) | (test_q & ~words[W_ISEL]);

  logic [NSRC-1:0] clr_rise, clr_fall, rise_q, fall_q, active;
  assign clr_rise = (wr_en && wr_addr == 6'h1E) ? wr_data : '0;
  assign clr_fall = (wr_en && wr_addr == 6'h1F) ? wr_data : '0;

  intc_detect #(.N(NSRC)) u_det (
    .clk(clk), .rst_n(rst_n), .src(src_sel),
    .cfg0(words[W_CFG0]), .cfg1(words[W_CFG1]), .cfg2(words[W_CFG2]),
    .clr_rise(clr_rise), .clr_fall(clr_fall),
    .rise_q(rise_q), .fall_q(fall_q), .active(active));

  logic [NSRC-1:0] pend0, pend1, wake_hit;
  assign pend0    = active & words[W_MASK] & words[W_ROUTE];
  assign pend1    = active & words[W_MASK] & ~words[W_ROUTE];
  assign wake_hit = active & words[W_WAKE];
  assign req0_o   = |pend0;
  assign req1_o   = |pend1;
  assign wake_o   = |wake_hit;

  always_comb begin
    rd_data = '0;
    if (!rhi) begin
      if (rgrp < 3'(NUM_WORDS)) begin
        if (rop == OP_READ) rd_data = words[rgrp];
      end else if (rop == 2'd0) begin
        rd_data = rise_q;
      end else if (rop == 2'd1) begin
        rd_data = fall_q;
      end
    end else begin
      case (rd_addr[4:0])
        5'h00:   rd_data = pend0;
        5'h01:   rd_data = pend1;
        5'h02:   rd_data = test_q;
        default: rd_data = '0;
      endcase
    end
  end

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (words[W_MASK] == '0) |-> (!req0_o && !req1_o)); // R8
  AST_NO_WAKE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (words[W_WAKE] == '0) |-> !wake_o); // R9
  AST_ROUTE_ALL0: assert property (@(posedge clk) disable iff (!rst_n)
    (words[W_ROUTE] == '0) |-> !req0_o); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(!rst_n) |-> (!req0_o && !req1_o && !wake_o)); // R1
endmodule

// File: tb/intc32_tb.sv
module intc32_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] irq_in = '0;
  logic        wr_en = 0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        req0_o, req1_o, wake_o;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;   // 250 MHz

  intc32 u_dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o));

  localparam logic [5:0] A_RISE = 6'h1C, A_FALL = 6'h1D, A_CLRR = 6'h1E, A_CLRF = 6'h1F;
  localparam logic [5:0] A_P0 = 6'h20, A_P1 = 6'h21, A_TRD = 6'h22, A_TWR = 6'h23;
  localparam int G_ISEL = 3, G_ROUTE = 4, G_WAKE = 5, G_MASK = 6;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  function automatic logic [5:0] ad(input int g, input int op);
    return 6'((g << 2) | op);
  endfunction

  task automatic cfg_src(input int i, input logic [2:0] code, input bit ext, input bit r0);
    for (int b = 0; b < 3; b++) wr(ad(b, code[b] ? 1 : 2), 32'd1 << i);
    wr(ad(G_ISEL, ext ? 1 : 2), 32'd1 << i);
    wr(ad(G_ROUTE, r0 ? 1 : 2), 32'd1 << i);
    wr(ad(G_MASK, 1), 32'd1 << i);
  endtask

  task automatic clear_all();
    for (int g = 0; g < 7; g++) wr(ad(g, 2), '1);
    wr(A_CLRR, '1); wr(A_CLRF, '1); wr(A_TWR, '0);
    irq_in = '0;
    repeat (4) @(negedge clk);
    wr(A_CLRR, '1); wr(A_CLRF, '1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int g = 0; g < 7; g++) begin rd(ad(g, 0), v); chk("R1 word", v, 0); end
    rd(A_RISE, v); chk("R1 rise", v, 0);
    rd(A_FALL, v); chk("R1 fall", v, 0);
    rd(A_TRD, v);  chk("R1 test", v, 0);
    chk("R1 outs", {req0_o, req1_o, wake_o}, 0);
  endtask

  task automatic t_setclr();
    logic [31:0] v;
    for (int g = 0; g < 7; g++) begin
      wr(ad(g, 1), 32'hF0F0_1234);
      wr(ad(g, 1), 32'h0000_0001);
      rd(ad(g, 0), v); chk("R2 set", v, 32'hF0F0_1235);
      wr(ad(g, 2), 32'h00F0_1200);
      rd(ad(g, 0), v); chk("R2 clr", v, 32'hF000_0035);
      wr(ad(g, 2), '1);
      rd(ad(g, 0), v); chk("R2 zero", v, 0);
    end
  endtask

  task automatic t_level();
    logic [31:0] v;
    cfg_src(5, 3'b101, 1, 1);
    irq_in[5] = 1;
    @(negedge clk); chk("R4 sync one edge", req0_o, 0);
    @(negedge clk); chk("R4 high after two", req0_o, 1);
    rd(A_P0, v); chk("R7 pend0", v, 32'h20);
    irq_in[5] = 0;
    repeat (2) @(negedge clk); chk("R4 high drops", req0_o, 0);
    cfg_src(9, 3'b110, 1, 0);
    @(negedge clk);
    chk("R4 low active", req1_o, 1);
    rd(A_P1, v); chk("R7 pend1", v, 32'h200);
    irq_in[9] = 1;
    repeat (2) @(negedge clk); chk("R4 low drops", req1_o, 0);
    clear_all();
  endtask

  task automatic t_edges();
    logic [31:0] v;
    cfg_src(3, 3'b001, 1, 1);
    cfg_src(4, 3'b010, 1, 1);
    cfg_src(6, 3'b011, 1, 1);
    irq_in[3] = 1; irq_in[4] = 1; irq_in[6] = 1;
    repeat (4) @(negedge clk);
    rd(A_RISE, v); chk("R5 rise latch", v, 32'h48);
    rd(A_FALL, v); chk("R5 no fall yet", v, 0);
    irq_in[3] = 0; irq_in[4] = 0; irq_in[6] = 0;
    repeat (4) @(negedge clk);
    rd(A_RISE, v); chk("R5 rise persists", v, 32'h48);
    rd(A_FALL, v); chk("R5 fall latch", v, 32'h50);
    rd(A_P0, v);   chk("R5 edge pending", v, 32'h58);
    wr(A_CLRR, 32'h8);
    rd(A_RISE, v); chk("R6 clear one rise", v, 32'h40);
    rd(A_P0, v);   chk("R6 pend after clr", v, 32'h50);
    wr(A_CLRF, 32'h50);
    rd(A_FALL, v); chk("R6 clear falls", v, 0);
    rd(A_P0, v);   chk("R6 both-mode keeps rise", v, 32'h40);
    wr(A_CLRR, 32'h40);
    chk("R6 req0 drops", req0_o, 0);
    clear_all();
  endtask

  task automatic t_mask_wake();
    logic [31:0] v;
    cfg_src(7, 3'b101, 1, 0);
    wr(ad(G_MASK, 2), 32'h80);
    irq_in[7] = 1;
    repeat (3) @(negedge clk);
    rd(A_P1, v); chk("R8 masked pend", v, 0);
    chk("R8 masked req", req1_o, 0);
    wr(ad(G_MASK, 1), 32'h80);
    chk("R8 unmasked req1", req1_o, 1);
    chk("R7 not on req0", req0_o, 0);
    wr(ad(G_MASK, 2), 32'h80);
    wr(ad(G_WAKE, 1), 32'h80);
    chk("R9 wake while masked", wake_o, 1);
    chk("R9 req still low", req1_o, 0);
    wr(ad(G_WAKE, 2), 32'h80);
    chk("R9 wake off", wake_o, 0);
    clear_all();
  endtask

  task automatic t_select();
    logic [31:0] v;
    cfg_src(12, 3'b101, 0, 1);
    irq_in[12] = 1;
    repeat (3) @(negedge clk);
    rd(A_P0, v); chk("R10 pin ignored", v, 0);
    wr(A_TWR, 32'h1000);
    rd(A_P0, v); chk("R10 test word drives", v, 32'h1000);
    rd(A_TRD, v); chk("R10 test readback", v, 32'h1000);
    wr(A_TWR, 32'h0);
    chk("R10 test word off", req0_o, 0);
    wr(ad(G_ISEL, 1), 32'h1000);
    chk("R10 pin selected", req0_o, 1);
    clear_all();
    cfg_src(13, 3'b000, 1, 1);
    wr(ad(G_WAKE, 1), 32'h2000);
    irq_in[13] = 1; repeat (4) @(negedge clk);
    irq_in[13] = 0; repeat (4) @(negedge clk);
    rd(A_RISE, v); chk("R3 no rise", v, 0);
    rd(A_FALL, v); chk("R3 no fall", v, 0);
    chk("R3 no req/wake", {req0_o, req1_o, wake_o}, 0);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_setclr();
    t_level();
    t_edges();
    t_mask_wake();
    t_select();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule